// File: doc/BRIEF.md
# Five-Input Reconfigurable Logic Tile

This tile realises an arbitrary Boolean function of five inputs using three identical 4-input look-up cells. The function is split on its lowest input `x_in[0]`. One cell holds the cofactor where that input is 1 and another holds the cofactor where it is 0; both are addressed by the remaining four inputs. A third cell is wired as a 2:1 selector that merges the two cofactors under control of `x_in[0]`. Each cell can be switched, by one configuration bit, between a combinational path and a D flip-flop at its output.

All configuration (three 16-bit tables and three register-select bits) lives in a 51-bit serial chain. Software or a loader holds `cfg_en` high and presents one bit per clock on `cfg_din`. While loading, every logic output is forced low. The two cofactor cell outputs are also brought out as taps so that they can be reused, for example as the first stage of a wide AND built in cascade.

Top module: `lut_cluster`

## Requirements
- R1: While `cfg_en` is 1, each rising edge shifts `cfg_din` into the chain, with bits entering at the top and moving towards bit 0. After 51 such edges, the i-th bit sent (counting from 0) sits at chain bit i. The chain layout is: bits 15:0 hold the cofactor-high table, bits 31:16 hold the cofactor-low table, bits 47:32 hold the selector table, bit 48 is the register select of the high cell, bit 49 is that of the low cell, and bit 50 is that of the selector cell.
- R2: While `cfg_en` is 1, `y_out`, `cof_hi_out` and `cof_lo_out` are 0 at every sample. Every flip-flop in the tile is cleared on each rising edge where `cfg_en` is 1.
- R3: Each cofactor cell uses `x_in[4:1]` as its address, with `x_in[4]` as the MSB. Its output is the table bit at that index.
- R4: The selector cell's address is {0, `x_in[0]`, high cell output, low cell output}, MSB first, and its output is the table bit at that index. With selector table 0x00CA, the three combinational cells give `y_out` = T[`x_in`] for any 32-bit truth table T. This holds when the high table is the odd bits of T and the low table is the even bits of T.
- R5: A register select bit of 1 makes that cell's output the value its lookup had at the previous rising edge. A select bit of 0 makes the output follow its address within the same cycle.
- R6: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears all three flip-flops but leaves the configuration chain unchanged.
- R7: `cof_hi_out` and `cof_lo_out` carry the high and low cell outputs after their optional registers. A non-Shannon selector table may combine these outputs, for example 0x00C0 with both cofactor tables at 0x8000, which yields a 5-input AND.
- R8: While `cfg_en` is 0, `cfg_din` is ignored and the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the chain and the flip-flops |
| rst_n | input | 1 | Synchronous active-low reset of the cell flip-flops |
| cfg_en | input | 1 | High while configuration bits are being shifted in |
| cfg_din | input | 1 | Serial configuration bit |
| x_in | input | 5 | Logic inputs; bit 0 is the Shannon split variable |
| y_out | output | 1 | Tile output from the selector cell |
| cof_hi_out | output | 1 | Output tap of the cofactor-high cell |
| cof_lo_out | output | 1 | Output tap of the cofactor-low cell |

## Verification
Two timing paths meet in the same cycle: the combinational lookup path and the registered path. This happens when some cells are registered and the selector cell reads a registered cofactor together with a fresh `x_in[0]`.

The bench applies each new input half a cycle before the edge. It judges every output twice: once just after the input changes, when bypassed cells must already show the new value and registered cells the old one, and once just after the edge, when all cells agree. Loading and reset are also exercised directly after registered runs, so that clearing the flip-flops and keeping the configuration are seen at the ports in the same sequence.

// File: rtl/lut_cluster_pkg.sv
// Package: shared sizing and chain layout for the five-input logic tile.
// Assumes cells have at least four address inputs so the selector fits.
package lut_cluster_pkg;
    parameter int CELL_K    = 4;                    // address inputs per cell
    parameter int NUM_CELLS = 3;                    // high, low, selector
    localparam int TBL_W    = 1 << CELL_K;          // table bits per cell
    localparam int REG_BASE = NUM_CELLS * TBL_W;    // first register-select bit
    localparam int CHAIN_W  = REG_BASE + NUM_CELLS; // total chain length
    localparam int NUM_X    = CELL_K + 1;           // tile logic inputs

    // Cell order inside the chain; the order fixes the chain layout.
    typedef enum int {
        CELL_HI  = 0,
        CELL_LO  = 1,
        CELL_SEL = 2
    } cell_idx_e;
endpackage

// File: rtl/cfg_chain.sv
// Module: serial configuration chain.
// Shifts one bit per clock while enabled, with new bits entering at the
// top so that the first bit sent ends at bit 0. Holds otherwise. Not reset.
module cfg_chain #(
    parameter int W = 51
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_din,
    output logic [W-1:0] cfg_word
);

    // Shift in at the top while loading, otherwise keep the contents.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            cfg_word <= {shift_din, cfg_word[W-1:1]};
        end
    end

    AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg_word[W-1] == $past(shift_din)) && (cfg_word[0] == $past(cfg_word[1]))); // R1

    AST_CHAIN_HOLD: assert property (@(posedge clk)
        !shift_en |=> $stable(cfg_word)); // R8

endmodule

// File: rtl/lut_cell.sv
// Module: one look-up cell with an optional output flip-flop.
// The address selects one table bit. reg_en picks the flip-flop output or
// the raw lookup. The flip-flop clears on synchronous reset or on clr.
module lut_cell #(
    parameter int K = 4,
    localparam int D = 1 << K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [D-1:0] tbl_bits,
    input  logic         reg_en,
    input  logic [K-1:0] addr,
    output logic         cell_out
);

    logic lut_bit;
    logic lut_q;

    // Pick the stored bit addressed by the inputs.
    always_comb begin
        lut_bit = tbl_bits[addr];
    end

    // Capture the lookup on each edge; clear on reset or during loading.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lut_q <= 1'b0;
        end else begin
            lut_q <= lut_bit;
        end
    end

    // Choose the registered or the bypassed path.
    always_comb begin
        cell_out = reg_en ? lut_q : lut_bit;
    end

    AST_RST_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lut_q == 1'b0)); // R6

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && reg_en && $stable(reg_en)) |=> (cell_out == $past(lut_bit))); // R5

endmodule

// File: rtl/lut_cluster.sv
// Module: five-input logic tile built from three look-up cells.
// The two cofactor cells read x_in[K:1]. The selector cell reads
// {0.., x_in[0], hi, lo}. Configuration comes from the serial chain.
// All outputs are forced to 0 while cfg_en is high. Assumes CELL_K >= 4.
module lut_cluster
    import lut_cluster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [NUM_X-1:0] x_in,
    output logic             y_out,
    output logic             cof_hi_out,
    output logic             cof_lo_out
);

    localparam int PAD_W = CELL_K - 3;

    logic [CHAIN_W-1:0] cfg_word;
    logic               cof_y [2];
    logic               sel_y;
    logic [CELL_K-1:0]  sel_addr;

    cfg_chain #(.W(CHAIN_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_en),
        .shift_din (cfg_din),
        .cfg_word  (cfg_word)
    );

    // The two cofactor cells share the upper inputs as their address.
    for (genvar g = 0; g < 2; g++) begin : g_cof
        lut_cell #(.K(CELL_K)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (cfg_en),
            .tbl_bits (cfg_word[g*TBL_W +: TBL_W]),
            .reg_en   (cfg_word[REG_BASE + g]),
            .addr     (x_in[NUM_X-1:1]),
            .cell_out (cof_y[g])
        );
    end

    // Build the selector address from the split input and both cofactors.
    always_comb begin
        sel_addr = {{PAD_W{1'b0}}, x_in[0], cof_y[CELL_HI], cof_y[CELL_LO]};
    end

    lut_cell #(.K(CELL_K)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_en),
        .tbl_bits (cfg_word[CELL_SEL*TBL_W +: TBL_W]),
        .reg_en   (cfg_word[REG_BASE + CELL_SEL]),
        .addr     (sel_addr),
        .cell_out (sel_y)
    );

    // Gate every output to 0 while configuration is loading.
    always_comb begin
        y_out      = cfg_en ? 1'b0 : sel_y;
        cof_hi_out = cfg_en ? 1'b0 : cof_y[CELL_HI];
        cof_lo_out = cfg_en ? 1'b0 : cof_y[CELL_LO];
    end

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (!y_out && !cof_hi_out && !cof_lo_out)); // R2

    AST_SHANNON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !cfg_word[REG_BASE + CELL_SEL]
         && cfg_word[CELL_SEL*TBL_W +: TBL_W] == 16'h00CA)
        |-> (y_out == (x_in[0] ? cof_hi_out : cof_lo_out))); // R4

endmodule

// File: tb/lut_cluster_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for the five-input logic tile. The driver pushes the
// expected (y, hi, lo) for the early sample (just after the inputs change)
// and the late sample (just after the edge). The monitor pops and compares.
module lut_cluster_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [4:0] x_in = 5'd0;
    logic       y_out, cof_hi_out, cof_lo_out;

    int tests = 0;
    int fails = 0;

    typedef struct {
        bit       late;
        bit [2:0] exp;
        string    tag;
    } item_t;
    item_t sb[$];

    // model state for the three flip-flops and current configuration
    bit        mq_hi, mq_lo, mq_sel;
    bit [15:0] m_hi, m_lo, m_sel;
    bit [2:0]  m_reg;

    always #2.5 clk = ~clk;

    lut_cluster u_lut_cluster (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_din    (cfg_din),
        .x_in       (x_in),
        .y_out      (y_out),
        .cof_hi_out (cof_hi_out),
        .cof_lo_out (cof_lo_out)
    );

    // model outputs {y, hi, lo} from requirements R3, R4, R5
    function automatic bit [2:0] model_out(input bit [4:0] x);
        bit h, l, hv, lv, s;
        h  = m_hi[x[4:1]];
        l  = m_lo[x[4:1]];
        hv = m_reg[0] ? mq_hi : h;
        lv = m_reg[1] ? mq_lo : l;
        s  = m_sel[{1'b0, x[0], hv, lv}];
        return {m_reg[2] ? mq_sel : s, hv, lv};
    endfunction

    function automatic void push(input bit late, input bit [2:0] e, input string t);
        item_t it;
        it.late = late;
        it.exp  = e;
        it.tag  = t;
        sb.push_back(it);
    endfunction

    // model edge: capture the pre-edge lookups
    function automatic void model_edge(input bit [4:0] x);
        bit h, l, hv, lv;
        h  = m_hi[x[4:1]];
        l  = m_lo[x[4:1]];
        hv = m_reg[0] ? mq_hi : h;
        lv = m_reg[1] ? mq_lo : l;
        mq_sel = m_sel[{1'b0, x[0], hv, lv}];
        mq_hi  = h;
        mq_lo  = l;
    endfunction

    // monitor: compare at each early and late sample point
    task automatic check(input bit late);
        item_t it;
        if (sb.size() > 0 && sb[0].late == late) begin
            it = sb.pop_front();
            tests++;
            if ({y_out, cof_hi_out, cof_lo_out} !== it.exp) begin
                fails++;
                $display("FAIL %s: {y,hi,lo} actual=%b expected=%b at %0t",
                         it.tag, {y_out, cof_hi_out, cof_lo_out}, it.exp, $time);
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk); #1; check(1'b0);
            @(posedge clk); #1; check(1'b1);
        end
    end

    // driver: shift a configuration in, checking quiet outputs (R1, R2)
    task automatic load(input bit [15:0] hi, input bit [15:0] lo,
                        input bit [15:0] sel, input bit [2:0] regs);
        bit [50:0] w;
        w = {regs, sel, lo, hi};
        for (int i = 0; i < 51; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
            push(1'b0, 3'b000, "R2");
            mq_hi = 0; mq_lo = 0; mq_sel = 0;
            push(1'b1, 3'b000, "R2");
        end
        m_hi = hi; m_lo = lo; m_sel = sel; m_reg = regs;
    endtask

    // driver: sweep all 32 inputs, random cfg_din while idle (R8)
    task automatic sweep(input string tag, input bit reverse);
        for (int v = 0; v < 32; v++) begin
            bit [4:0] x;
            x = reverse ? 5'(31 - v) : 5'(v);
            @(negedge clk);
            cfg_en  = 1'b0;
            cfg_din = 1'($urandom);
            x_in    = x;
            push(1'b0, model_out(x), tag);
            model_edge(x);
            push(1'b1, model_out(x), tag);
        end
    endtask

    // split a truth table into odd (x0=1) and even (x0=0) cofactors (R4)
    function automatic bit [15:0] cof(input bit [31:0] t, input bit odd);
        bit [15:0] c;
        for (int j = 0; j < 16; j++) c[j] = t[2*j + (odd ? 1 : 0)];
        return c;
    endfunction

    task automatic shannon(input bit [31:0] t, input bit [2:0] regs, input string tag);
        load(cof(t, 1'b1), cof(t, 1'b0), 16'h00CA, regs);
        sweep(tag, 1'b0);
        sweep(tag, 1'b1);
        if (regs == 3'b000) begin
            // comb mode: late y must equal the truth table directly (R4)
            for (int v = 0; v < 32; v++) begin
                @(negedge clk);
                cfg_din = 1'($urandom);
                x_in = 5'(v);
                push(1'b1, {t[v], t[{v[4:1], 1'b1}], t[{v[4:1], 1'b0}]}, "R4,R3");
                model_edge(5'(v));
            end
        end
    endtask

    initial begin
        bit [31:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        shannon(32'h96696996, 3'b000, "R1,R3,R4,R8");
        shannon(32'h80000000, 3'b000, "R1,R4");
        t = $urandom;
        shannon(t, 3'b000, "R4,R8");
        t = $urandom;
        shannon(t, 3'b100, "R5");
        t = $urandom;
        shannon(t, 3'b011, "R5,R7");
        t = $urandom;
        shannon(t, 3'b111, "R5");
        // R6: reset clears flip-flops, configuration survives
        @(negedge clk);
        rst_n = 1'b0;
        x_in = 5'd21;
        mq_hi = 0; mq_lo = 0; mq_sel = 0;
        push(1'b1, model_out(5'd21), "R6");
        @(negedge clk);
        rst_n = 1'b1;
        push(1'b0, model_out(5'd21), "R6");
        model_edge(5'd21);
        push(1'b1, model_out(5'd21), "R6");
        sweep("R6", 1'b0);
        // R7: cascade, wide AND from cofactor taps and a custom selector
        load(16'h8000, 16'h8000, 16'h00C0, 3'b000);
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            cfg_din = 1'($urandom);
            cfg_en = 1'b0;
            x_in = 5'(v);
            push(1'b0, {(v == 31) ? 1'b1 : 1'b0, (v[4:1] == 4'hF) ? 1'b1 : 1'b0,
                        (v[4:1] == 4'hF) ? 1'b1 : 1'b0}, "R7");
            model_edge(5'(v));
        end
        sweep("R7", 1'b1);
        wait (sb.size() == 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog: a hung run is counted as a failure
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule